// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns a decoded memory-access descriptor into the byte address a load or store uses, and into the new value of the base register when the access updates its base. A single adder serves four modes: plain indirect (address is the base), base plus offset (no update), pre-indexed (the updated base is both the address and the writeback value) and post-indexed (the old base is the address, the updated base is written back). The offset is either a 12-bit unsigned immediate or a full 32-bit second register value, and a direction bit selects addition or subtraction.

When the base register index is 15, the program counter is the base, and it is read as the instruction address plus 8. Writeback is never requested for that register. The result is registered and comes with a one-cycle valid strobe, one cycle after the request strobe. Register reads, operand shifting, memory and decode all sit outside this unit.

Top module: `agu_top`

## Requirements
- R1: While rst_n is low at a clock edge, every output is cleared to zero at that edge.
- R2: rsp_valid is high for exactly one cycle, in the cycle after each cycle in which req_valid was high, and is low otherwise. The other outputs are updated only when a request is taken.
- R3: Mode code 0 (indirect): rsp_addr equals the base value and rsp_wb_en is 0. Any offset inputs have no effect on rsp_addr.
- R4: Mode code 1 (offset): rsp_addr equals base plus or minus the offset, and rsp_wb_en is 0.
- R5: Mode code 2 (pre-indexed): rsp_addr equals base plus or minus the offset, rsp_wb_en is 1, rsp_wb_idx equals req_base_idx, and rsp_wb_val equals rsp_addr.
- R6: Mode code 3 (post-indexed): rsp_addr equals the unmodified base, rsp_wb_en is 1, and rsp_wb_val equals base plus or minus the offset.
- R7: With req_use_reg = 0, the offset is req_imm zero-extended from 12 bits. It is added when req_sub = 0 and subtracted when req_sub = 1.
- R8: With req_use_reg = 1, the offset is req_off_reg and req_imm has no effect. Direction is chosen by req_sub in the same way.
- R9: When req_base_idx is 15, the base is req_pc + 8 and req_base_val has no effect. rsp_wb_en is 0 for every mode.
- R10: rsp_byte repeats req_byte. A byte access uses the same address arithmetic as a word access, with no scaling of the offset.
- R11: All sums and differences wrap modulo 2^32.
- R12: Start from base 0x1000 and apply a run of four accesses: indirect, offset +4, post-indexed +4 and pre-indexed +4. Each writeback is fed into the next access. The addresses are 0x1000, 0x1004, 0x1000 and 0x1008, and the final base is 0x1008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | Mode code: 0 indirect, 1 offset, 2 pre-indexed, 3 post-indexed |
| req_base_idx | input | 4 | Base register index; 15 selects the program counter |
| req_base_val | input | 32 | Base register value |
| req_pc | input | 32 | Address of the current instruction |
| req_use_reg | input | 1 | 1 selects the register offset, 0 the immediate |
| req_imm | input | 12 | Unsigned immediate offset magnitude |
| req_off_reg | input | 32 | Register offset value |
| req_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| req_byte | input | 1 | 1 for a byte access, 0 for a word access |
| rsp_valid | output | 1 | Result strobe |
| rsp_addr | output | 32 | Effective address |
| rsp_byte | output | 1 | Access size of the result |
| rsp_wb_en | output | 1 | Base register writeback request |
| rsp_wb_idx | output | 4 | Register to write back |
| rsp_wb_val | output | 32 | Value to write back |

## Verification
Each mode is run with the same base and offset. This shows that the four modes differ only in which of base and sum becomes the address and in whether writeback is raised. Immediate and register offsets are applied in both directions, each with a distracting value on the unused source, so a wrong source select shows up in the address. Index 15 is run with a base value unrelated to the PC, which exposes both a missing +8 and a writeback that was not suppressed. Wrap-around cases at both ends of the address space and the chained four-access run check the arithmetic and the writeback feed.

// File: rtl/agu_pkg.sv
// Shared types and constants for the address generation unit.
// Assumes a 32-bit address space and 16 architectural registers.
package agu_pkg;
    localparam int AGU_AW    = 32;
    localparam int AGU_IDXW  = 4;
    localparam int AGU_IMMW  = 12;

    // Mode code order is decoded by the instruction decoder outside.
    typedef enum logic [1:0] {
        AM_INDIRECT = 2'd0,
        AM_OFFSET   = 2'd1,
        AM_PRE      = 2'd2,
        AM_POST     = 2'd3
    } addr_mode_e;
endpackage

// File: rtl/agu_base_sel.sv
// Base operand selector: substitutes the read-ahead program counter
// when the base index names the PC register. Purely combinational.
// Assumes the PC is the highest register index.
module agu_base_sel #(
    parameter int AW       = 32,
    parameter int IDXW     = 4,
    parameter int PC_AHEAD = 8
) (
    input  logic [IDXW-1:0] base_idx,
    input  logic [AW-1:0]   base_val,
    input  logic [AW-1:0]   pc,
    output logic [AW-1:0]   eff_base,
    output logic            base_is_pc
);
    localparam logic [IDXW-1:0] PC_IDX   = {IDXW{1'b1}};
    localparam logic [AW-1:0]   AHEAD_AW = AW'(PC_AHEAD);

    // Pick the register value or the PC seen by the executing instruction.
    always_comb begin
        base_is_pc = (base_idx == PC_IDX);
        eff_base   = base_is_pc ? (pc + AHEAD_AW) : base_val;
    end
endmodule

// File: rtl/agu_offset_unit.sv
// Offset adder: selects the immediate or register offset and adds it to
// or subtracts it from the base, wrapping modulo 2^AW.
// REG_OFF_EN = 0 builds an immediate-only variant.
module agu_offset_unit #(
    parameter int AW         = 32,
    parameter int IMMW       = 12,
    parameter bit REG_OFF_EN = 1'b1
) (
    input  logic [AW-1:0]   base,
    input  logic            use_reg,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   off_reg,
    input  logic            sub,
    output logic [AW-1:0]   sum
);
    localparam int PADW = AW - IMMW;

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] offset;
    logic [AW-1:0] operand;

    // Zero-extend the immediate magnitude.
    always_comb imm_ext = {{PADW{1'b0}}, imm};

    generate
        if (REG_OFF_EN) begin : g_reg_off
            // Choose between register and immediate offset.
            always_comb offset = use_reg ? off_reg : imm_ext;
        end else begin : g_imm_only
            logic unused_ok;
            // Register offset is not supported; tie off its inputs.
            always_comb unused_ok = use_reg ^ (^off_reg);
            always_comb offset    = imm_ext;
        end
    endgenerate

    // Two's-complement negate for subtraction, then a single adder.
    always_comb begin
        operand = sub ? (~offset + {{(AW-1){1'b0}}, 1'b1}) : offset;
        sum     = base + operand;
    end
endmodule

// File: rtl/agu_mode_mux.sv
// Mode steering: decides which of the base and the offset sum drives the
// address and the writeback value, and whether writeback is requested.
// Assumes base_is_pc already reflects PC substitution.
module agu_mode_mux
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  addr_mode_e    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] sum,
    input  logic          base_is_pc,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wb_val,
    output logic          wb_req
);
    logic mode_updates;

    // Select address source and writeback request per mode.
    always_comb begin
        wb_val = sum;
        unique case (mode)
            AM_INDIRECT: begin addr = base; mode_updates = 1'b0; end
            AM_OFFSET:   begin addr = sum;  mode_updates = 1'b0; end
            AM_PRE:      begin addr = sum;  mode_updates = 1'b1; end
            AM_POST:     begin addr = base; mode_updates = 1'b1; end
            default:     begin addr = base; mode_updates = 1'b0; end
        endcase
        wb_req = mode_updates && !base_is_pc;
    end
endmodule

// File: rtl/agu_top.sv
// Load/store address generation unit, top level. Combines base
// selection, offset arithmetic and mode steering, then registers the
// result with a one-cycle valid strobe. Assumes operands are stable in
// the cycle req_valid is high. Synchronous active-low reset.
module agu_top
    import agu_pkg::*;
#(
    parameter int AW       = AGU_AW,
    parameter int IDXW     = AGU_IDXW,
    parameter int IMMW     = AGU_IMMW,
    parameter int PC_AHEAD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_mode,
    input  logic [IDXW-1:0] req_base_idx,
    input  logic [AW-1:0]   req_base_val,
    input  logic [AW-1:0]   req_pc,
    input  logic            req_use_reg,
    input  logic [IMMW-1:0] req_imm,
    input  logic [AW-1:0]   req_off_reg,
    input  logic            req_sub,
    input  logic            req_byte,
    output logic            rsp_valid,
    output logic [AW-1:0]   rsp_addr,
    output logic            rsp_byte,
    output logic            rsp_wb_en,
    output logic [IDXW-1:0] rsp_wb_idx,
    output logic [AW-1:0]   rsp_wb_val
);
    localparam logic [IDXW-1:0] PC_IDX = {IDXW{1'b1}};

    logic [AW-1:0] eff_base;
    logic          base_is_pc;
    logic [AW-1:0] sum;
    logic [AW-1:0] addr_c;
    logic [AW-1:0] wb_val_c;
    logic          wb_req_c;
    addr_mode_e    mode_e;

    // Interpret the raw mode code as the package enum.
    always_comb mode_e = addr_mode_e'(req_mode);

    agu_base_sel #(
        .AW(AW), .IDXW(IDXW), .PC_AHEAD(PC_AHEAD)
    ) u_base_sel (
        .base_idx   (req_base_idx),
        .base_val   (req_base_val),
        .pc         (req_pc),
        .eff_base   (eff_base),
        .base_is_pc (base_is_pc)
    );

    agu_offset_unit #(
        .AW(AW), .IMMW(IMMW), .REG_OFF_EN(1'b1)
    ) u_offset (
        .base    (eff_base),
        .use_reg (req_use_reg),
        .imm     (req_imm),
        .off_reg (req_off_reg),
        .sub     (req_sub),
        .sum     (sum)
    );

    agu_mode_mux #(
        .AW(AW)
    ) u_mode_mux (
        .mode       (mode_e),
        .base       (eff_base),
        .sum        (sum),
        .base_is_pc (base_is_pc),
        .addr       (addr_c),
        .wb_val     (wb_val_c),
        .wb_req     (wb_req_c)
    );

    // Strobe generation: one result cycle per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_wb_en <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_wb_en <= req_valid && wb_req_c;
        end
    end

    // Result capture: payload updates only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr   <= '0;
            rsp_byte   <= 1'b0;
            rsp_wb_idx <= '0;
            rsp_wb_val <= '0;
        end else if (req_valid) begin
            rsp_addr   <= addr_c;
            rsp_byte   <= req_byte;
            rsp_wb_idx <= req_base_idx;
            rsp_wb_val <= wb_val_c;
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R2
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb_en |-> rsp_valid);

    // R9
    no_pc_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb_en |-> (rsp_wb_idx != PC_IDX));

    // R3
    indirect_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd0) |=> !rsp_wb_en);

    // R4
    offset_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1) |=> !rsp_wb_en);

    // R5
    pre_addr_is_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd2) |=> (rsp_wb_val == rsp_addr));

    // R6
    post_wb_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd3 && req_base_idx != PC_IDX) |=> rsp_wb_en);

    // R10
    byte_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_byte == $past(req_byte)));
endmodule

// File: tb/agu_top_tb.sv
// Directed bench for agu_top: one task per scenario, each checking itself.
module agu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_mode;
    logic [3:0]  req_base_idx;
    logic [31:0] req_base_val;
    logic [31:0] req_pc;
    logic        req_use_reg;
    logic [11:0] req_imm;
    logic [31:0] req_off_reg;
    logic        req_sub;
    logic        req_byte;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_byte;
    logic        rsp_wb_en;
    logic [3:0]  rsp_wb_idx;
    logic [31:0] rsp_wb_val;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    agu_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_base_idx(req_base_idx), .req_base_val(req_base_val), .req_pc(req_pc),
        .req_use_reg(req_use_reg), .req_imm(req_imm), .req_off_reg(req_off_reg),
        .req_sub(req_sub), .req_byte(req_byte), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_byte(rsp_byte), .rsp_wb_en(rsp_wb_en),
        .rsp_wb_idx(rsp_wb_idx), .rsp_wb_val(rsp_wb_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Issue one request at a falling edge and sample the result one cycle later.
    task automatic issue(input logic [1:0] mode, input logic [3:0] idx,
                         input logic [31:0] base, input logic [31:0] pc,
                         input logic use_reg, input logic [11:0] imm,
                         input logic [31:0] oreg, input logic sub, input logic bsz);
        req_valid = 1'b1; req_mode = mode; req_base_idx = idx; req_base_val = base;
        req_pc = pc; req_use_reg = use_reg; req_imm = imm; req_off_reg = oreg;
        req_sub = sub; req_byte = bsz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Independent model of the requirements, then compare every output.
    task automatic run_check(input string tag, input logic [1:0] mode, input logic [3:0] idx,
                             input logic [31:0] base, input logic [31:0] pc,
                             input logic use_reg, input logic [11:0] imm,
                             input logic [31:0] oreg, input logic sub, input logic bsz);
        logic [31:0] b, off, s, ea;
        logic wb;
        b   = (idx == 4'd15) ? pc + 32'd8 : base;
        off = use_reg ? oreg : {20'd0, imm};
        s   = sub ? b - off : b + off;
        ea  = (mode == 2'd1 || mode == 2'd2) ? s : b;
        wb  = (mode >= 2'd2) && (idx != 4'd15);
        issue(mode, idx, base, pc, use_reg, imm, oreg, sub, bsz);
        chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " addr"},  rsp_addr, ea);
        chk({tag, " byte"},  {31'd0, rsp_byte}, {31'd0, bsz});
        chk({tag, " wb_en"}, {31'd0, rsp_wb_en}, {31'd0, wb});
        if (wb) begin
            chk({tag, " wb_idx"}, {28'd0, rsp_wb_idx}, {28'd0, idx});
            chk({tag, " wb_val"}, rsp_wb_val, s);
        end
    endtask

    task automatic t_reset;   // R1
        chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 addr",  rsp_addr, 32'd0);
        chk("R1 wb_en", {31'd0, rsp_wb_en}, 32'd0);
        chk("R1 wb_val", rsp_wb_val, 32'd0);
        chk("R1 wb_idx", {28'd0, rsp_wb_idx}, 32'd0);
        chk("R1 byte", {31'd0, rsp_byte}, 32'd0);
    endtask

    task automatic t_modes;   // R3 R4 R5 R6 with the same operands
        run_check("R3 indirect", 2'd0, 4'd2, 32'h0000_2000, 32'h0, 1'b0, 12'h040, 32'h0, 1'b0, 1'b0);
        chk("R3 addr ignores imm", rsp_addr, 32'h0000_2000);
        run_check("R4 offset", 2'd1, 4'd2, 32'h0000_2000, 32'h0, 1'b0, 12'h040, 32'h0, 1'b0, 1'b0);
        run_check("R5 pre", 2'd2, 4'd2, 32'h0000_2000, 32'h0, 1'b0, 12'h040, 32'h0, 1'b0, 1'b0);
        run_check("R6 post", 2'd3, 4'd2, 32'h0000_2000, 32'h0, 1'b0, 12'h040, 32'h0, 1'b0, 1'b0);
        chk("R6 addr is old base", rsp_addr, 32'h0000_2000);
        chk("R6 wb_val", rsp_wb_val, 32'h0000_2040);
    endtask

    task automatic t_offsets; // R7 R8
        run_check("R7 imm sub", 2'd1, 4'd6, 32'h0000_1000, 32'h0, 1'b0, 12'h240, 32'hDEAD_0000, 1'b1, 1'b0);
        chk("R7 addr", rsp_addr, 32'h0000_0DC0);
        run_check("R7 imm max", 2'd1, 4'd6, 32'h0001_0000, 32'h0, 1'b0, 12'hFFF, 32'h5, 1'b0, 1'b0);
        chk("R7 addr max", rsp_addr, 32'h0001_0FFF);
        run_check("R8 reg add", 2'd2, 4'd1, 32'h0000_3000, 32'h0, 1'b1, 12'h7FF, 32'h0001_0004, 1'b0, 1'b0);
        chk("R8 addr ignores imm", rsp_addr, 32'h0001_3004);
        run_check("R8 reg sub", 2'd3, 4'd4, 32'h0000_3000, 32'h0, 1'b1, 12'h001, 32'h0000_0100, 1'b1, 1'b0);
        chk("R8 wb_val", rsp_wb_val, 32'h0000_2F00);
    endtask

    task automatic t_pc;      // R9
        run_check("R9 pc pre", 2'd2, 4'd15, 32'h5555_5555, 32'h0000_0100, 1'b0, 12'h010, 32'h0, 1'b0, 1'b0);
        chk("R9 addr pc+8+16", rsp_addr, 32'h0000_0118);
        chk("R9 no wb", {31'd0, rsp_wb_en}, 32'd0);
        run_check("R9 pc post", 2'd3, 4'd15, 32'h5555_5555, 32'h0000_0200, 1'b0, 12'h004, 32'h0, 1'b0, 1'b0);
        chk("R9 addr pc+8", rsp_addr, 32'h0000_0208);
    endtask

    task automatic t_byte;    // R10
        run_check("R10 byte", 2'd1, 4'd1, 32'h0000_4000, 32'h0, 1'b0, 12'h001, 32'h0, 1'b0, 1'b1);
        chk("R10 addr unscaled", rsp_addr, 32'h0000_4001);
        chk("R10 size", {31'd0, rsp_byte}, 32'd1);
    endtask

    task automatic t_wrap;    // R11
        run_check("R11 wrap up", 2'd2, 4'd3, 32'hFFFF_FFFC, 32'h0, 1'b0, 12'h008, 32'h0, 1'b0, 1'b0);
        chk("R11 addr up", rsp_addr, 32'h0000_0004);
        run_check("R11 wrap down", 2'd1, 4'd3, 32'h0000_0000, 32'h0, 1'b1, 12'h000, 32'h0000_0001, 1'b1, 1'b0);
        chk("R11 addr down", rsp_addr, 32'hFFFF_FFFF);
    endtask

    task automatic t_strobe;  // R2
        issue(2'd1, 4'd2, 32'h10, 32'h0, 1'b0, 12'h1, 32'h0, 1'b0, 1'b0);
        chk("R2 pulse high", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R2 pulse ends", {31'd0, rsp_valid}, 32'd0);
        chk("R2 wb low when idle", {31'd0, rsp_wb_en}, 32'd0);
        chk("R2 payload held", rsp_addr, 32'h11);
        issue(2'd0, 4'd2, 32'h20, 32'h0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0);
        issue(2'd0, 4'd2, 32'h30, 32'h0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0);
        chk("R2 back-to-back", {31'd0, rsp_valid}, 32'd1);
        chk("R2 second addr", rsp_addr, 32'h30);
    endtask

    task automatic t_sequence; // R12
        logic [31:0] b;
        b = 32'h1000;
        issue(2'd0, 4'd5, b, 32'h0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0);
        chk("R12 step1 addr", rsp_addr, 32'h1000);
        if (rsp_wb_en) b = rsp_wb_val;
        issue(2'd1, 4'd5, b, 32'h0, 1'b0, 12'h4, 32'h0, 1'b0, 1'b0);
        chk("R12 step2 addr", rsp_addr, 32'h1004);
        if (rsp_wb_en) b = rsp_wb_val;
        issue(2'd3, 4'd5, b, 32'h0, 1'b0, 12'h4, 32'h0, 1'b0, 1'b0);
        chk("R12 step3 addr", rsp_addr, 32'h1000);
        if (rsp_wb_en) b = rsp_wb_val;
        issue(2'd2, 4'd5, b, 32'h0, 1'b0, 12'h4, 32'h0, 1'b0, 1'b0);
        chk("R12 step4 addr", rsp_addr, 32'h1008);
        if (rsp_wb_en) b = rsp_wb_val;
        chk("R12 final base", b, 32'h1008);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_base_idx = 4'd0;
        req_base_val = 32'h0; req_pc = 32'h0; req_use_reg = 1'b0; req_imm = 12'h0;
        req_off_reg = 32'h0; req_sub = 1'b0; req_byte = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_modes();
        t_offsets();
        t_pc();
        t_byte();
        t_wrap();
        t_strobe();
        t_sequence();
        done = 1'b1;
    end

    // Watchdog and single exit point.
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule